// File: doc/BRIEF.md
# E1 Time-Slot 16 Signaling Merger

This block builds the channel-associated signaling content of an E1 transmit bit stream. Serial system data arrives one bit per clock. A sync pulse marks the first bit of time-slot 0 in frame 0 of a sixteen-frame signaling multiframe. The block keeps its own bit, time-slot and frame position from that pulse and chooses, bit by bit, what goes onto the merged serial output.

Signaling comes from two places. Sixteen internal byte registers hold one time-slot 16 byte per frame. Software writes them into a shadow copy, and they go live together at the next multiframe boundary. An external serial signaling input can also be merged directly into the system stream, frame-aligned. In time-slots 0 and 16 it replaces the whole byte. In every other time-slot it replaces only the low nibble. A mode input chooses between line-side insertion, where only internal bytes are used, and system-side insertion, where external signaling is merged and internal bytes still take precedence in time-slot 16.

Top module: `e1_cas_ts16_merger`

## Requirements
- R1: After reset `ser_out` is 0 and no internal byte is marked as supplied, so in line-side mode every time-slot 16 bit passes `sys_data_in` until a supplied byte has been loaded.
- R2: A high `sync_in` makes the current bit frame 0, time-slot 0, bit 1. A frame has 32 time-slots of 8 bits (256 clocks) and a multiframe has 16 frames (4096 clocks). A sync pulse in the middle of a multiframe realigns all of these counts at once.
- R3: `ser_out` shows the merged value of an input bit one clock after that bit is presented.
- R4: In line-side mode (`sys_side_ins`=0), every bit outside supplied time-slot 16 bytes equals `sys_data_in`, and `ext_sig_in` has no effect.
- R5: When internal byte f is supplied, time-slot 16 of frame f carries that byte MSB first: bit 1 of the time-slot is byte bit 7.
- R6: In frame 0, when an internal byte is used, bits 1 to 4 of time-slot 16 are forced to 0000 (multiframe alignment) whatever the register holds.
- R7: In system-side mode (`sys_side_ins`=1), in time-slots other than 0 and 16, bits 1 to 4 come from `sys_data_in` and `ext_sig_in` is ignored there; bits 5 to 8 come from `ext_sig_in`.
- R8: In system-side mode, all eight bits of time-slot 0 come from `ext_sig_in`. All eight bits of time-slot 16 also come from `ext_sig_in` when that frame's internal byte is not supplied.
- R9: In system-side mode a supplied internal byte replaces the external signaling in time-slot 16 of its frame.
- R10: A write with `wr_en`=1 stores `wr_data` and the supplied flag `wr_supply` for byte `wr_addr` in a shadow copy. All shadow bytes move to the active set on the last bit of a multiframe (frame 15, time-slot 31, bit 8). A write therefore changes nothing before the next multiframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit system bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Marks bit 1 of time-slot 0, frame 0 |
| sys_data_in | input | 1 | Serial system data |
| ext_sig_in | input | 1 | Serial external signaling |
| sys_side_ins | input | 1 | 1 = system-side insertion with external merge, 0 = line-side |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Internal byte index (frame number) |
| wr_data | input | 8 | Byte value |
| wr_supply | input | 1 | 1 marks the byte as supplied, 0 releases it |
| ser_out | output | 1 | Merged serial output |

## Verification
The bench walks complete multiframes in both modes, comparing every output bit with a model that it derives from the position count, and it checks the nibble boundary at bit 4/5 of ordinary time-slots and the full-byte slots 0 and 16. If the nibble split were misplaced or reversed, system data would leak into signaling bits or the reverse. If the frame 0 alignment nibble were not forced, register bits would show in bits 1 to 4. Writes land mid-multiframe, and the bench checks the rest of that multiframe: a design without a shadow copy would change time-slot 16 too early. A sync pulse placed mid-multiframe catches counters that do not restart, and an unsupplied byte in system-side mode catches priority logic that overrides external data with stale register contents.

// File: rtl/cas_pkg.sv
package cas_pkg;

    localparam int unsigned BITS_PER_TS   = 8;
    localparam int unsigned TS_PER_FRAME  = 32;
    localparam int unsigned FRAMES_PER_MF = 16;
    localparam int unsigned SIG_TS        = 16;
    localparam int unsigned NIBBLE_START  = 4;
    localparam int unsigned SIG_BYTES     = FRAMES_PER_MF;

    localparam int unsigned BIT_W  = $clog2(BITS_PER_TS);
    localparam int unsigned TS_W   = $clog2(TS_PER_FRAME);
    localparam int unsigned FR_W   = $clog2(FRAMES_PER_MF);
    localparam int unsigned ADDR_W = FR_W;

    typedef logic [BITS_PER_TS-1:0] sig_byte_t;

    typedef struct packed {
        logic [FR_W-1:0]  fr;
        logic [TS_W-1:0]  ts;
        logic [BIT_W-1:0] bitn;
    } mf_pos_t;

    typedef enum logic [1:0] {
        SRC_SYS = 2'd0,
        SRC_EXT = 2'd1,
        SRC_INT = 2'd2
    } bit_src_e;

    function automatic mf_pos_t pos_advance(mf_pos_t p);
        mf_pos_t n;
        n = p;
        if (p.bitn == BIT_W'(BITS_PER_TS - 1)) begin
            n.bitn = '0;
            if (p.ts == TS_W'(TS_PER_FRAME - 1)) begin
                n.ts = '0;
                n.fr = (p.fr == FR_W'(FRAMES_PER_MF - 1)) ? '0 : p.fr + 1'b1;
            end else begin
                n.ts = p.ts + 1'b1;
            end
        end else begin
            n.bitn = p.bitn + 1'b1;
        end
        return n;
    endfunction

    function automatic logic pos_is_last(mf_pos_t p);
        return (p.bitn == BIT_W'(BITS_PER_TS - 1)) &&
               (p.ts == TS_W'(TS_PER_FRAME - 1)) &&
               (p.fr == FR_W'(FRAMES_PER_MF - 1));
    endfunction

    function automatic logic ts_full_ext(logic [TS_W-1:0] ts);
        return (ts == '0) || (ts == TS_W'(SIG_TS));
    endfunction

endpackage

// File: rtl/e1_mf_counter.sv
module e1_mf_counter
    import cas_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sync,
    output mf_pos_t cur_pos,
    output logic    mf_last
);

    mf_pos_t pos_q;

    assign cur_pos = sync ? '0 : pos_q;
    assign mf_last = pos_is_last(cur_pos);

    always_ff @(posedge clk) begin
        if (rst) pos_q <= '0;
        else     pos_q <= pos_advance(cur_pos);
    end

    AST_TS_HOLD_IN_BYTE: assert property (@(posedge clk) disable iff (rst)
        (!sync && cur_pos.bitn != BIT_W'(BITS_PER_TS - 1))
        |=> (sync || cur_pos.ts == $past(cur_pos.ts))); // R2

    AST_BIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!sync && cur_pos.bitn != BIT_W'(BITS_PER_TS - 1))
        |=> (sync || cur_pos.bitn == $past(cur_pos.bitn) + 1'b1)); // R2

endmodule

// File: rtl/cas_sig_store.sv
module cas_sig_store
    import cas_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  sig_byte_t         wr_data,
    input  logic              wr_supply,
    input  logic              load,
    input  logic [ADDR_W-1:0] rd_addr,
    output sig_byte_t         rd_byte,
    output logic              rd_valid
);

    sig_byte_t shadow_q [SIG_BYTES];
    logic      shadow_v [SIG_BYTES];
    sig_byte_t act_q    [SIG_BYTES];
    logic      act_v    [SIG_BYTES];

    for (genvar i = 0; i < SIG_BYTES; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q[i] <= '0;
                shadow_v[i] <= 1'b0;
                act_q[i]    <= '0;
                act_v[i]    <= 1'b0;
            end else begin
                if (wr_en && wr_addr == ADDR_W'(i)) begin
                    shadow_q[i] <= wr_data;
                    shadow_v[i] <= wr_supply;
                end
                if (load) begin
                    act_q[i] <= shadow_q[i];
                    act_v[i] <= shadow_v[i];
                end
            end
        end

        AST_ACT_HOLD: assert property (@(posedge clk) disable iff (rst)
            !load |=> ($stable(act_q[i]) && $stable(act_v[i]))); // R10
    end

    assign rd_byte  = act_q[rd_addr];
    assign rd_valid = act_v[rd_addr];

endmodule

// File: rtl/cas_bit_select.sv
module cas_bit_select
    import cas_pkg::*;
(
    input  mf_pos_t   pos,
    input  logic      sys_side,
    input  logic      sys_bit,
    input  logic      ext_bit,
    input  sig_byte_t int_byte,
    input  logic      int_valid,
    output logic      sel_bit,
    output bit_src_e  src
);

    logic [BIT_W-1:0] msb_idx;
    logic             in_sig_ts;
    logic             fas_nibble;

    assign msb_idx    = BIT_W'(BITS_PER_TS - 1) - pos.bitn;
    assign in_sig_ts  = (pos.ts == TS_W'(SIG_TS));
    assign fas_nibble = (pos.fr == '0) && (pos.bitn < BIT_W'(NIBBLE_START));

    always_comb begin
        if (in_sig_ts && int_valid)
            src = SRC_INT;
        else if (sys_side && (ts_full_ext(pos.ts) || pos.bitn >= BIT_W'(NIBBLE_START)))
            src = SRC_EXT;
        else
            src = SRC_SYS;
    end

    always_comb begin
        unique case (src)
            SRC_INT: sel_bit = fas_nibble ? 1'b0 : int_byte[msb_idx];
            SRC_EXT: sel_bit = ext_bit;
            default: sel_bit = sys_bit;
        endcase
    end

endmodule

// File: rtl/e1_cas_ts16_merger.sv
module e1_cas_ts16_merger
    import cas_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sync_in,
    input  logic                   sys_data_in,
    input  logic                   ext_sig_in,
    input  logic                   sys_side_ins,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [BITS_PER_TS-1:0] wr_data,
    input  logic                   wr_supply,
    output logic                   ser_out
);

    mf_pos_t   cur_pos;
    logic      mf_last;
    sig_byte_t int_byte;
    logic      int_valid;
    logic      sel_bit;
    bit_src_e  src;

    e1_mf_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .sync    (sync_in),
        .cur_pos (cur_pos),
        .mf_last (mf_last)
    );

    cas_sig_store u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_supply (wr_supply),
        .load      (mf_last),
        .rd_addr   (cur_pos.fr),
        .rd_byte   (int_byte),
        .rd_valid  (int_valid)
    );

    cas_bit_select u_sel (
        .pos       (cur_pos),
        .sys_side  (sys_side_ins),
        .sys_bit   (sys_data_in),
        .ext_bit   (ext_sig_in),
        .int_byte  (int_byte),
        .int_valid (int_valid),
        .sel_bit   (sel_bit),
        .src       (src)
    );

    always_ff @(posedge clk) begin
        if (rst) ser_out <= 1'b0;
        else     ser_out <= sel_bit;
    end

    AST_LINE_PASS: assert property (@(posedge clk) disable iff (rst)
        (!sys_side_ins && cur_pos.ts != TS_W'(SIG_TS))
        |=> ser_out == $past(sys_data_in)); // R4

    AST_LOW_NIBBLE_SYS: assert property (@(posedge clk) disable iff (rst)
        (sys_side_ins && !ts_full_ext(cur_pos.ts) && cur_pos.bitn < BIT_W'(NIBBLE_START))
        |=> ser_out == $past(sys_data_in)); // R7

    AST_FULL_EXT: assert property (@(posedge clk) disable iff (rst)
        (sys_side_ins && ts_full_ext(cur_pos.ts) &&
         !(cur_pos.ts == TS_W'(SIG_TS) && int_valid))
        |=> ser_out == $past(ext_sig_in)); // R8

    AST_FAS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cur_pos.ts == TS_W'(SIG_TS) && cur_pos.fr == '0 && int_valid &&
         cur_pos.bitn < BIT_W'(NIBBLE_START))
        |=> !ser_out); // R6

endmodule

// File: tb/e1_cas_ts16_merger_tb.sv
`timescale 1ns/1ps
module e1_cas_ts16_merger_tb;

    localparam int MF_BITS  = 4096;
    localparam int WATCHDOG = 60000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_in = 1'b0;
    logic       sys_data_in = 1'b0;
    logic       ext_sig_in = 1'b0;
    logic       sys_side_ins = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       wr_supply = 1'b0;
    logic       ser_out;

    always #2 clk = ~clk;

    e1_cas_ts16_merger u_dut (
        .clk          (clk),
        .rst          (rst),
        .sync_in      (sync_in),
        .sys_data_in  (sys_data_in),
        .ext_sig_in   (ext_sig_in),
        .sys_side_ins (sys_side_ins),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .wr_supply    (wr_supply),
        .ser_out      (ser_out)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // bench-side model state
    logic [7:0] sh_b [16];
    logic       sh_v [16];
    logic [7:0] ac_b [16];
    logic       ac_v [16];
    int         kb = 0;
    bit         ever_loaded = 0;
    bit         realigned = 0;
    bit         have_prev = 0;
    logic       exp_prev;
    string      tag_prev;
    logic [15:0] lfsr_s = 16'hACE1;
    logic [15:0] lfsr_e = 16'h1D3B;

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: ser_out=%0b expected %0b (time %0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] lfsr_next(input logic [15:0] l);
        return {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
    endfunction

    // one bit period: check previous output, drive new inputs, update model
    task automatic step(input bit s, input bit mode, input bit we,
                        input int addr, input logic [7:0] data, input bit sup);
        int fr, ts, b;
        logic e;
        string t;
        @(negedge clk);
        if (have_prev) check(tag_prev, ser_out, exp_prev); // R3: one-clock latency on every check
        sync_in      = s;
        sys_side_ins = mode;
        sys_data_in  = lfsr_s[0];
        ext_sig_in   = lfsr_e[3];
        wr_en        = we;
        wr_addr      = addr[3:0];
        wr_data      = data;
        wr_supply    = sup;
        if (s) kb = 0;
        fr = kb / 256;
        ts = (kb / 8) % 32;
        b  = kb % 8;
        if (ts == 16 && ac_v[fr])
            e = (fr == 0 && b < 4) ? 1'b0 : ac_b[fr][7 - b];
        else if (mode && (ts == 0 || ts == 16 || b >= 4))
            e = ext_sig_in;
        else
            e = sys_data_in;
        if (ts == 16 && (sh_v[fr] != ac_v[fr] || (sh_v[fr] && sh_b[fr] != ac_b[fr])))
            t = "R10";
        else if (realigned && ts == 16)
            t = "R2";
        else if (ts == 16 && ac_v[fr])
            t = (fr == 0 && b < 4) ? "R6" : (mode ? "R9" : "R5");
        else if (!mode)
            t = (ts == 16 && !ever_loaded) ? "R1" : (ts == 0 ? "R3" : "R4");
        else
            t = (ts == 0 || ts == 16) ? "R8" : "R7";
        if (kb == MF_BITS - 1) begin
            for (int i = 0; i < 16; i++) begin
                ac_b[i] = sh_b[i];
                ac_v[i] = sh_v[i];
                if (sh_v[i]) ever_loaded = 1;
            end
            realigned = 0;
        end
        if (we) begin
            sh_b[addr] = data;
            sh_v[addr] = sup;
        end
        kb = (kb + 1) % MF_BITS;
        lfsr_s = lfsr_next(lfsr_s);
        lfsr_e = lfsr_next(lfsr_e ^ 16'h0005);
        exp_prev  = e;
        tag_prev  = t;
        have_prev = 1;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            sh_b[i] = '0; sh_v[i] = 0; ac_b[i] = '0; ac_v[i] = 0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", ser_out, 1'b0); // reset value

        // MF1: line side, writes land mid-multiframe into the shadow copy
        for (int c = 0; c < MF_BITS; c++) begin
            if (c >= 300 && c < 316)
                step(c == 0, 0, 1, c - 300, 8'h5A ^ 8'((c - 300) * 37), (c - 300) != 5);
            else
                step(c == 0, 0, 0, 0, 8'h00, 0);
        end
        // MF2: line side with supplied bytes
        for (int c = 0; c < MF_BITS; c++) step(0, 0, 0, 0, 8'h00, 0);
        // MF3: system side; bytes 0..3 released mid-multiframe
        for (int c = 0; c < MF_BITS; c++) begin
            if (c >= 100 && c < 104) step(0, 1, 1, c - 100, 8'hFF, 0);
            else                     step(0, 1, 0, 0, 8'h00, 0);
        end
        // MF4: system side, then a sync in mid-multiframe
        for (int c = 0; c < 1000; c++) step(0, 1, 0, 0, 8'h00, 0);
        step(1, 1, 0, 0, 8'h00, 0);
        realigned = 1;
        for (int c = 0; c < MF_BITS + 600; c++) step(0, c >= MF_BITS ? 1'b0 : 1'b1, 0, 0, 8'h00, 0);
        @(negedge clk);
        check(tag_prev, ser_out, exp_prev);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule